// File: doc/BRIEF.md
# Rotating Delayed-Cancellation Filter for Synchronous-Frame Samples

This block is a fixed-point streaming filter placed between a three-phase Park transform and the loop controller of a grid synchronizer. It takes one (d, q) pair per accepted sample. A DC offset on the three phase voltages shows up in the synchronous frame as a vector that turns at one fundamental turn per period. The filter removes that vector. The fundamental positive-sequence component shows up as a constant vector, and the filter passes it with a known gain and a known phase shift.

For every accepted pair the block fetches the pair accepted `PERIOD_SAMPLES/DELAY_N` samples earlier. It rotates that older pair by the fixed angle π + 2π/n, where n is `DELAY_N`, adds it to the current pair and halves the sum. The rotation constants are fixed at elaboration from n. The delay is counted in accepted samples, so it equals T/n only when the producer delivers `PERIOD_SAMPLES` samples per grid period.

Both streams use valid/ready. A producer must hold `in_d` and `in_q` steady while `in_valid` is high and `in_ready` is low. The consumer may stall with `out_ready` low. The block then holds its result and drops `in_ready`, so back-pressure reaches the producer within the same cycle. No input is lost and no output is duplicated.

Top module: `rdsc_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: After reset, the first D = PERIOD_SAMPLES/DELAY_N accepted pairs only fill the delay store and produce no output. With the defaults, D is 25.
- R3: For an accepted pair (d, q) whose partner (a, b) was accepted D samples earlier, the d result is (d + rnd(a·C) − rnd(b·S)) >>> 1. Here C = round(−cos(2π/n)·2^15), S = round(−sin(2π/n)·2^15), each clamped to [−32768, 32767]. rnd(x) = (x + 2^14) >>> 15, and >>> is an arithmetic shift, so results round toward −∞.
- R4: Under the same conditions, the q result is (q + rnd(b·C) + rnd(a·S)) >>> 1.
- R5: The delay counts accepted pairs only. Cycles with `in_valid` low, or with the input stalled, do not advance it.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_d`, `out_q` and `out_valid` hold their values on the next cycle, and `in_ready` is 0.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. Every accepted pair from index D onward yields exactly one output in the cycle after it is accepted.
- R8: For a constant input vector of magnitude A, the output magnitude is A·sin(π/n) within 2 LSB.
- R9: For a constant input on the d axis only, the output angle atan2(q, d) is −(π/2 − π/n) within 0.01 rad.
- R10: An input d = A·cos(2πk/200), q = A·sin(2πk/200), which is how a phase DC offset appears in this frame, is cancelled to a magnitude of at most 3 LSB once the delay store holds only that pattern.
- R11: Full-scale inputs, including −32768 on both channels, give the exact R3 and R4 results without wrapping. The outputs are DATA_W+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take the input pair this cycle |
| in_d | input | DATA_W | Signed d sample |
| in_q | input | DATA_W | Signed q sample |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair this cycle |
| out_d | output | DATA_W+1 | Signed filtered d |
| out_q | output | DATA_W+1 | Signed filtered q |

## Verification
A constant vector along d exercises the pass path. The bench checks gain and angle (R8, R9), which separates a correct rotation constant from a wrong sign or a wrong quadrant. A vector turning once per 200 samples must vanish (R10), and only the right delay depth together with the right angle gives that null. Random data, random gaps on `in_valid` and random stalls on `out_ready` are compared bit for bit with a queue-based model on every clock. These runs expose rounding, shift or delay-count faults, and faults in the handshake. Full-scale values and a reset in the middle of the stream check the headroom and the refill of the delay store.

// File: rtl/rdsc_pkg.sv
package rdsc_pkg;

  localparam real PI_R = 3.14159265358979323846;

  function automatic real series_cos(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int i = 1; i < 30; i++) begin
      term = -term * x * x / ((2 * i - 1) * (2 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real series_sin(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int i = 1; i < 30; i++) begin
      term = -term * x * x / ((2 * i) * (2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // value scaled by 2^frac, rounded to nearest, clamped to signed range
  function automatic int to_fixed(input real v, input int frac);
    real scale;
    int  r;
    int  hi;
    int  lo;
    scale = 1.0;
    for (int i = 0; i < frac; i++) scale = scale * 2.0;
    r  = int'(v * scale);
    hi = (1 << frac) - 1;
    lo = -(1 << frac);
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  // rotation angle is pi + 2*pi/n
  function automatic int rot_cos_fixed(input int n, input int frac);
    return to_fixed(-series_cos(2.0 * PI_R / n), frac);
  endfunction

  function automatic int rot_sin_fixed(input int n, input int frac);
    return to_fixed(-series_sin(2.0 * PI_R / n), frac);
  endfunction

endpackage

// File: rtl/rdsc_delay_line.sv
module rdsc_delay_line #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] old_data,
  output logic             primed
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] slot;

  // the entry about to be overwritten is the one pushed DEPTH pushes ago
  assign old_data = store[slot];

  always_ff @(posedge clk) begin
    if (push) store[slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      primed <= 1'b0;
    end else if (push) begin
      if (slot == LAST) begin
        slot   <= '0;
        primed <= 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdsc_rotator.sv
module rdsc_rotator #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int COS_K  = 0,
  parameter int SIN_K  = 0,
  localparam int TERM_W = DATA_W + 1,
  localparam int ROT_W  = DATA_W + 2
) (
  input  logic signed [DATA_W-1:0] a_d,
  input  logic signed [DATA_W-1:0] a_q,
  output logic signed [ROT_W-1:0] r_d,
  output logic signed [ROT_W-1:0] r_q
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [COEF_W-1:0] KC = COEF_W'(COS_K);
  localparam logic signed [COEF_W-1:0] KS = COEF_W'(SIN_K);
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC - 1);

  logic signed [DATA_W-1:0] src [2];
  logic signed [COEF_W-1:0] coef [2];
  logic signed [TERM_W-1:0] term [2][2];

  assign src[0]  = a_d;
  assign src[1]  = a_q;
  assign coef[0] = KC;
  assign coef[1] = KS;

  // term[i][j] = rnd(src[i] * coef[j])
  for (genvar i = 0; i < 2; i++) begin : g_src
    for (genvar j = 0; j < 2; j++) begin : g_coef
      logic signed [PROD_W-1:0] prod;
      logic signed [PROD_W-1:0] biased;
      logic signed [PROD_W-1:0] shifted;
      always_comb begin
        prod    = PROD_W'(src[i]) * PROD_W'(coef[j]);
        biased  = prod + HALF;
        shifted = biased >>> FRAC;
      end
      assign term[i][j] = shifted[TERM_W-1:0];
    end
  end

  always_comb begin
    r_d = ROT_W'(term[0][0]) - ROT_W'(term[1][1]);
    r_q = ROT_W'(term[1][0]) + ROT_W'(term[0][1]);
  end
endmodule

// File: rtl/rdsc_avg_out.sv
module rdsc_avg_out #(
  parameter int DATA_W = 16,
  localparam int ROT_W = DATA_W + 2,
  localparam int SUM_W = DATA_W + 3,
  localparam int OUT_W = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  logic                    emit,
  input  logic signed [DATA_W-1:0] cur_d,
  input  logic signed [DATA_W-1:0] cur_q,
  input  logic signed [ROT_W-1:0]  rot_d,
  input  logic signed [ROT_W-1:0]  rot_q,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0]  out_d,
  output logic signed [OUT_W-1:0]  out_q
);
  logic signed [SUM_W-1:0] sum_d;
  logic signed [SUM_W-1:0] sum_q;

  always_comb begin
    sum_d = SUM_W'(cur_d) + SUM_W'(rot_d);
    sum_q = SUM_W'(cur_q) + SUM_W'(rot_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= emit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // halving: drop bit 0, keep sign (floor)
  always_ff @(posedge clk) begin
    if (fire && emit) begin
      out_d <= sum_d[OUT_W:1];
      out_q <= sum_q[OUT_W:1];
    end
  end
endmodule

// File: rtl/rdsc_filter.sv
module rdsc_filter #(
  parameter int DATA_W         = 16,
  parameter int COEF_W         = 16,
  parameter int PERIOD_SAMPLES = 200,
  parameter int DELAY_N        = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [DATA_W-1:0] in_d,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [DATA_W:0]   out_d,
  output logic signed [DATA_W:0]   out_q
);
  localparam int DEPTH  = PERIOD_SAMPLES / DELAY_N;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int ROT_W  = DATA_W + 2;
  localparam int COS_K  = rdsc_pkg::rot_cos_fixed(DELAY_N, COEF_W - 1);
  localparam int SIN_K  = rdsc_pkg::rot_sin_fixed(DELAY_N, COEF_W - 1);

  logic                    fire;
  logic                    primed;
  logic [PAIR_W-1:0]       old_pair;
  logic signed [DATA_W-1:0] old_d;
  logic signed [DATA_W-1:0] old_q;
  logic signed [ROT_W-1:0]  rot_d;
  logic signed [ROT_W-1:0]  rot_q;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  rdsc_delay_line #(
    .WIDTH (PAIR_W),
    .DEPTH (DEPTH)
  ) u_dly (
    .clk      (clk),
    .rst      (rst),
    .push     (fire),
    .wr_data  ({in_d, in_q}),
    .old_data (old_pair),
    .primed   (primed)
  );

  assign old_d = old_pair[PAIR_W-1:DATA_W];
  assign old_q = old_pair[DATA_W-1:0];

  rdsc_rotator #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .COS_K  (COS_K),
    .SIN_K  (SIN_K)
  ) u_rot (
    .a_d (old_d),
    .a_q (old_q),
    .r_d (rot_d),
    .r_q (rot_q)
  );

  rdsc_avg_out #(
    .DATA_W (DATA_W)
  ) u_avg (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .emit      (primed),
    .cur_d     (in_d),
    .cur_q     (in_q),
    .rot_d     (rot_d),
    .rot_q     (rot_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_d     (out_d),
    .out_q     (out_q)
  );
endmodule

// File: rtl/rdsc_filter_chk.sv
module rdsc_filter_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W:0]   out_d,
  input logic [DATA_W:0]   out_q
);
  localparam int CNT_W = $clog2(DEPTH + 2) + 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DEPTH + 1);

  logic [CNT_W-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst) taken <= '0;
    else if (in_valid && in_ready && taken != LIM) taken <= taken + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  a_r2_no_early_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (taken == LIM));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_d) && $stable(out_q)));

  a_r6_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_one_out_per_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && taken >= CNT_W'(DEPTH)) |=> out_valid);

  a_r7_drain_without_input: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid);
endmodule

bind rdsc_filter rdsc_filter_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (PERIOD_SAMPLES / DELAY_N)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_d     (out_d),
  .out_q     (out_q)
);

// File: tb/rdsc_filter_test.sv
module rdsc_filter_test;
  localparam int DW    = 16;
  localparam int NDEL  = 8;
  localparam int PER   = 200;
  localparam int DEPTH = PER / NDEL;
  localparam real PI   = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] in_d = '0;
  logic signed [DW-1:0] in_q = '0;
  logic in_ready;
  logic out_valid;
  logic signed [DW:0] out_d;
  logic signed [DW:0] out_q;

  int vectors = 0;
  int fails = 0;
  int mode = 0;        // 0 exact only, 1 constant-vector gain/angle, 2 null
  real amp = 0.0;
  string tag = "R3 R4";
  bit done = 0;

  rdsc_filter #(.DATA_W(DW), .COEF_W(16), .PERIOD_SAMPLES(PER), .DELAY_N(NDEL)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_d(in_d), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_d(out_d), .out_q(out_q));

  always #2.5 clk = ~clk;

  function automatic int qfix(real v);
    int r;
    r = int'(v * 32768.0);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  int KC, KS;
  initial begin
    KC = qfix(-$cos(2.0 * PI / NDEL));
    KS = qfix(-$sin(2.0 * PI / NDEL));
  end

  function automatic int rmul(int x, int c);
    return (x * c + 16384) >>> 15;
  endfunction

  // behavioural reference: queue of accepted pairs
  int hd[$];
  int hq[$];
  bit m_valid = 0;
  int m_d = 0;
  int m_q = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0;
      hd.delete();
      hq.delete();
    end else if (in_valid && (!m_valid || out_ready)) begin
      hd.push_back(int'(in_d));
      hq.push_back(int'(in_q));
      if (hd.size() > DEPTH) begin
        int a, b;
        a = hd.pop_front();
        b = hq.pop_front();
        m_d <= (int'(in_d) + rmul(a, KC) - rmul(b, KS)) >>> 1;
        m_q <= (int'(in_q) + rmul(b, KC) + rmul(a, KS)) >>> 1;
        m_valid <= 1;
      end else begin
        m_valid <= 0;
      end
    end else if (out_ready) begin
      m_valid <= 0;
    end
  end

  task automatic fail_line(string req, int act, int exp);
    fails++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      vectors++;
      if (out_valid !== m_valid) fail_line("R2 R7 valid", int'(out_valid), int'(m_valid));
      if (in_ready !== (!m_valid || out_ready)) fail_line("R6 R7 ready", int'(in_ready), int'(!m_valid || out_ready));
      if (m_valid && out_valid) begin
        if (int'(out_d) != m_d) fail_line({tag, " d"}, int'(out_d), m_d);
        if (int'(out_q) != m_q) fail_line({tag, " q"}, int'(out_q), m_q);
        if (mode == 1) begin
          real mag, ang, emag, eang;
          mag  = $sqrt(real'(out_d) * real'(out_d) + real'(out_q) * real'(out_q));
          emag = amp * $sin(PI / NDEL);
          ang  = $atan2(real'(out_q), real'(out_d));
          eang = -(PI / 2.0 - PI / NDEL);
          vectors++;
          if (mag > emag + 2.0 || mag < emag - 2.0) fail_line("R8 gain", int'(mag), int'(emag));
          vectors++;
          if (ang > eang + 0.01 || ang < eang - 0.01) fail_line("R9 angle mrad", int'(ang * 1000.0), int'(eang * 1000.0));
        end else if (mode == 2) begin
          real mag;
          mag = $sqrt(real'(out_d) * real'(out_d) + real'(out_q) * real'(out_q));
          vectors++;
          if (mag > 3.0) fail_line("R10 null", int'(mag), 0);
        end
      end
    end
  end

  task automatic push(int d, int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_d = DW'(d);
    in_q = DW'(q);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    vectors++;
    if (out_valid !== 1'b0) fail_line("R1 out_valid", int'(out_valid), 0);
    vectors++;
    if (in_ready !== 1'b1) fail_line("R1 in_ready", int'(in_ready), 1);
  endtask

  initial begin
    do_reset();

    // R2 R8 R9: constant vector on d axis
    amp = 20000.0;
    tag = "R3 R4";
    for (int k = 0; k < 3 * DEPTH; k++) begin
      push(20000, 0);
      if (k == DEPTH + 1) mode = 1;
    end
    mode = 0;

    // R10: vector turning once per 200 samples
    for (int k = 0; k < 120; k++) begin
      push(int'(20000.0 * $cos(2.0 * PI * k / 200.0)), int'(20000.0 * $sin(2.0 * PI * k / 200.0)));
      if (k == DEPTH + 2) mode = 2;
    end
    mode = 0;
    idle(3);

    // R5 R6 R7: random data, gaps and stalls
    tag = "R5 R3 R4";
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 9) < 7) begin
        in_valid = 1'b1;
        in_d = DW'($urandom);
        in_q = DW'($urandom);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
    idle(3);

    // R11: full-scale extremes
    tag = "R11 R3 R4";
    for (int k = 0; k < 4 * DEPTH; k++) begin
      case (k % 4)
        0: push(-32768, -32768);
        1: push(32767, 32767);
        2: push(-32768, 32767);
        default: push(32767, -32768);
      endcase
    end
    idle(2);

    // R2: reset mid-stream, store must refill
    for (int k = 0; k < 10; k++) push(1000 * k, -500 * k);
    do_reset();
    tag = "R2 R3 R4";
    for (int k = 0; k < 2 * DEPTH; k++) push(300 * k - 7000, 12000 - 450 * k);
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule